// File: doc/BRIEF.md
# Peripheral security attribute controller

This block holds one security attribute bit per peripheral and drives the whole vector to the rest of the chip. A bit at 1 marks its peripheral as non-secure. A bit at 0 marks it as secure. Software never writes the vector directly. It writes a mask to a "make non-secure" register, which sets bits, or to a "make secure" register, which clears bits. It reads the result back from a status register, which is read-only.

The 32-bit vector is split into two halves of 16 bits each. Each half has its own group of three words: status, make non-secure and make secure. The bus is a simple register bus with a byte address, a write strobe, write data and registered read data. Bits that no peripheral owns are held at secure and cannot be changed.

Top module: `sec_attr_ctrl`

## Requirements
- R1: After reset, `attr_o` is all zero, so every peripheral is secure, and `bus_rdata` is zero.
- R2: The word index is `bus_addr[7:2]`, and `bus_addr[1:0]` is ignored. Word 0 is status, word 1 is make non-secure and word 2 is make secure, all for attribute bits 15:0. Words 3, 4 and 5 hold the same three registers for bits 31:16. A write to one group never changes the other group's bits.
- R3: Writing to a make non-secure word sets every `attr_o` bit of that group whose write data bit is 1. Bits written with 0 keep their value.
- R4: Writing to a make secure word clears every `attr_o` bit of that group whose write data bit is 1. Bits written with 0 keep their value.
- R5: A read of a status word returns that group's 16 attribute bits in data bits 15:0, where 1 means non-secure. Data bits 31:16 read as 0.
- R6: A read of a make non-secure word or of a make secure word always returns 0.
- R7: Attribute bits 10 to 15 and 25 to 31 are unassigned. They stay 0 whatever is written. The assigned mask is 0x01FF03FF.
- R8: Write data bits 31:16 have no effect on either group.
- R9: A write to a status word, or to any word index from 6 to 63, leaves `attr_o` unchanged. A read of any word index from 6 to 63 returns 0.
- R10: A write takes effect on the clock edge that accepts it, so `attr_o` and a status read in the next cycle show the new value. `bus_rdata` is registered. After an edge it holds the word addressed at that edge, as it was before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write mask |
| bus_rdata | output | 32 | Registered read data |
| attr_o | output | 32 | Attribute vector, where 1 means non-secure |

## Verification
Two things happen at the same clock edge: a write is applied, and the read register captures the addressed word. Every access in the sweeps is a read and a write together at one address, so each edge exercises both. The bench checks that the captured read data is the value from before the write, and that the next status read and `attr_o` show the value after the write. Writes to a set or clear word are also checked to read back 0 in the same access, while the status word they changed reports the new bits one access later.

// File: rtl/sec_attr_pkg.sv
package sec_attr_pkg;

  localparam int unsigned REGS_PER_GRP = 3;

  typedef enum logic [1:0] {
    REG_STATUS    = 2'd0,
    REG_MAKE_NSEC = 2'd1,
    REG_MAKE_SEC  = 2'd2,
    REG_NONE      = 2'd3
  } reg_kind_e;

  // Apply one set or clear mask to a group's bits, then force the unowned bits to 0
  function automatic logic [31:0] next_attr(input logic [31:0] cur,
                                            input logic [31:0] mask,
                                            input logic        do_set,
                                            input logic        do_clr,
                                            input logic [31:0] legal);
    logic [31:0] v;
    v = cur;
    if (do_set) v = v | mask;
    if (do_clr) v = v & ~mask;
    return v & legal;
  endfunction

endpackage

// File: rtl/sec_attr_decode.sv
module sec_attr_decode
  import sec_attr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_GRP = 2,
  localparam int unsigned IDX_W  = ADDR_W - 2,
  localparam int unsigned GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [GIDX_W-1:0] grp
);

  logic [IDX_W-1:0] word_idx;
  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    kind = REG_NONE;
    grp  = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int k = 0; k < REGS_PER_GRP; k++) begin
        if (word_idx == IDX_W'(g * REGS_PER_GRP + k)) begin
          kind = reg_kind_e'(2'(k));
          grp  = GIDX_W'(g);
        end
      end
    end
  end

endmodule

// File: rtl/sec_attr_group.sv
module sec_attr_group
  import sec_attr_pkg::*;
#(
  parameter int unsigned     GRP_W = 16,
  parameter logic [GRP_W-1:0] LEGAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             make_nsec,
  input  logic             make_sec,
  input  logic [GRP_W-1:0] wmask,
  output logic [GRP_W-1:0] state
);

  logic [GRP_W-1:0] state_nx;

  assign state_nx = GRP_W'(next_attr(32'(state), 32'(wmask),
                                     make_nsec, make_sec, 32'(LEGAL)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= state_nx;
  end

endmodule

// File: rtl/sec_attr_rdport.sv
module sec_attr_rdport
  import sec_attr_pkg::*;
#(
  parameter int unsigned GRP_W   = 16,
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  reg_kind_e                kind,
  input  logic [GIDX_W-1:0]        grp,
  input  logic [NUM_GRP*GRP_W-1:0] states,
  output logic [DATA_W-1:0]        rdata
);

  logic [GRP_W-1:0]  picked;
  logic [DATA_W-1:0] rdata_nx;

  assign picked   = states[grp*GRP_W +: GRP_W];
  assign rdata_nx = (kind == REG_STATUS) ? DATA_W'(picked) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rdata_nx;
  end

endmodule

// File: rtl/sec_attr_ctrl.sv
module sec_attr_ctrl
  import sec_attr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GRP_W   = 16,
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned DATA_W  = 32,
  parameter logic [NUM_GRP*GRP_W-1:0] ASSIGNED = 32'h01FF_03FF,
  localparam int unsigned ATTR_W = NUM_GRP * GRP_W,
  localparam int unsigned GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [ATTR_W-1:0] attr_o
);

  // Decode results and write strobes, kept as named wires so the checker can see them
  reg_kind_e          hit_kind;
  logic [GIDX_W-1:0]  hit_grp;
  logic [NUM_GRP-1:0] wr_make_nsec;
  logic [NUM_GRP-1:0] wr_make_sec;

  sec_attr_decode #(
    .ADDR_W  (ADDR_W),
    .NUM_GRP (NUM_GRP)
  ) u_decode (
    .addr (bus_addr),
    .kind (hit_kind),
    .grp  (hit_grp)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign wr_make_nsec[g] = bus_we && (hit_kind == REG_MAKE_NSEC) && (hit_grp == GIDX_W'(g));
    assign wr_make_sec[g]  = bus_we && (hit_kind == REG_MAKE_SEC)  && (hit_grp == GIDX_W'(g));

    sec_attr_group #(
      .GRP_W (GRP_W),
      .LEGAL (ASSIGNED[g*GRP_W +: GRP_W])
    ) u_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .make_nsec (wr_make_nsec[g]),
      .make_sec  (wr_make_sec[g]),
      .wmask     (bus_wdata[GRP_W-1:0]),
      .state     (attr_o[g*GRP_W +: GRP_W])
    );
  end

  sec_attr_rdport #(
    .GRP_W   (GRP_W),
    .NUM_GRP (NUM_GRP),
    .DATA_W  (DATA_W)
  ) u_rdport (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (hit_kind),
    .grp    (hit_grp),
    .states (attr_o),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/sec_attr_ctrl_chk.sv
module sec_attr_ctrl_chk
  import sec_attr_pkg::*;
#(
  parameter int unsigned GRP_W   = 16,
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned DATA_W  = 32,
  parameter logic [NUM_GRP*GRP_W-1:0] ASSIGNED = 32'h01FF_03FF,
  localparam int unsigned GIDX_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [DATA_W-1:0]        bus_wdata,
  input logic [DATA_W-1:0]        bus_rdata,
  input logic [NUM_GRP*GRP_W-1:0] attr_o,
  input reg_kind_e                hit_kind,
  input logic [GIDX_W-1:0]        hit_grp,
  input logic [NUM_GRP-1:0]       wr_make_nsec,
  input logic [NUM_GRP-1:0]       wr_make_sec
);

  logic [GRP_W-1:0] sel_status;
  logic             any_wr;
  assign sel_status = attr_o[hit_grp*GRP_W +: GRP_W];
  assign any_wr     = (|wr_make_nsec) || (|wr_make_sec);

  AST_UNOWNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (attr_o & ~ASSIGNED) == '0); // R7

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_make_nsec, wr_make_sec})); // R2

  AST_QUIET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_wr |=> $stable(attr_o)); // R9

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_kind != REG_STATUS) |=> bus_rdata == '0); // R6

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_kind == REG_STATUS) |=> bus_rdata == DATA_W'($past(sel_status))); // R5

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_make_nsec[g] |=>
        ((attr_o[g*GRP_W +: GRP_W] & $past(bus_wdata[GRP_W-1:0]))
          == ($past(bus_wdata[GRP_W-1:0]) & ASSIGNED[g*GRP_W +: GRP_W]))); // R3
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_make_sec[g] |=>
        ((attr_o[g*GRP_W +: GRP_W] & $past(bus_wdata[GRP_W-1:0])) == '0)); // R4
  end

endmodule

bind sec_attr_ctrl sec_attr_ctrl_chk #(
  .GRP_W    (GRP_W),
  .NUM_GRP  (NUM_GRP),
  .DATA_W   (DATA_W),
  .ASSIGNED (ASSIGNED)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .attr_o       (attr_o),
  .hit_kind     (hit_kind),
  .hit_grp      (hit_grp),
  .wr_make_nsec (wr_make_nsec),
  .wr_make_sec  (wr_make_sec)
);

// File: tb/sec_attr_ctrl_tb.sv
module sec_attr_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam logic [31:0] OWNED = 32'h01FF_03FF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] attr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_attr_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .attr_o    (attr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input int idx, input logic [31:0] st);
    if (idx == 0) return {16'h0, st[15:0]};
    if (idx == 3) return {16'h0, st[31:16]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] exp_write(input int idx, input logic [31:0] st,
                                            input logic [31:0] d);
    logic [31:0] lo, hi;
    lo = {16'h0, d[15:0]};
    hi = {d[15:0], 16'h0};
    case (idx)
      1: return (st | lo) & OWNED;
      2: return st & ~lo;
      4: return (st | hi) & OWNED;
      5: return st & ~hi;
      default: return st;
    endcase
  endfunction

  // One access: read capture and optional write at the same edge
  task automatic access(input logic [7:0] a, input logic we, input logic [31:0] d);
    int idx;
    logic [31:0] rd_exp;
    string rtag, wtag;
    idx    = int'(a[7:2]);
    rd_exp = exp_read(idx, model);
    if (we) model = exp_write(idx, model, d);
    rtag = (idx == 0 || idx == 3) ? "R5 status read" :
           (idx < 6) ? "R6 write-only read" : "R9 undefined read";
    wtag = !we ? "R10 idle" :
           (idx == 1 || idx == 4) ? "R3 make non-secure" :
           (idx == 2 || idx == 5) ? "R4 make secure" : "R9 ignored write";
    @(negedge clk);
    bus_addr  = a;
    bus_we    = we;
    bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
    check(rtag, bus_rdata, rd_exp);
    check(wtag, attr_o, model);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [6];
    logic [31:0] lfsr;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'h0000_0000; pats[2] = 32'hAAAA_5555;
    pats[3] = 32'h5555_AAAA; pats[4] = 32'h0F0F_F00F; pats[5] = 32'h1234_8421;
    lfsr = 32'hACE1_1357;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset attr", attr_o, 32'h0);
    check("R1 reset rdata", bus_rdata, 32'h0);

    // Read-only sweep of every byte address
    for (int a = 0; a < 256; a++) access(8'(a), 1'b0, 32'h0);

    // Explicit corner cases
    access(8'h04, 1'b1, 32'hFFFF_FFFF);
    check("R7 unowned stay zero", attr_o, 32'h0000_03FF);
    access(8'h10, 1'b1, 32'hFFFF_0000);
    check("R8 upper data ignored", attr_o, 32'h0000_03FF);
    check("R2 group isolation", attr_o[31:16], 16'h0);
    access(8'h13, 1'b1, 32'h0000_FFFF);
    check("R2 upper group set", attr_o, 32'h01FF_03FF);
    access(8'h0C, 1'b0, 32'h0);
    access(8'h0C, 1'b0, 32'h0);
    check("R10 status after write", bus_rdata, 32'h0000_01FF);
    access(8'h09, 1'b1, 32'h0000_0021);
    access(8'h00, 1'b1, 32'hFFFF_FFFF);
    check("R9 status write ignored", attr_o, 32'h01FF_03DE);
    access(8'h14, 1'b1, 32'hFFFF_FFFF);
    access(8'h14, 1'b0, 32'h0);
    check("R10 cleared upper", attr_o, 32'h0000_03DE);

    // Write sweep over every word index with several masks, then read both status words
    for (int w = 0; w < 64; w++) begin
      for (int p = 0; p < 7; p++) begin
        logic [31:0] d;
        if (p < 6) d = pats[p];
        else begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          d = lfsr;
        end
        access(8'((w << 2) | (p & 3)), 1'b1, d);
        access(8'h00, 1'b0, 32'h0);
        access(8'h0C, 1'b0, 32'h0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule